// File: doc/BRIEF.md
# Golomb Run-Length Encoder, Group Size Four

This block compresses a byte stream with Golomb coding at a fixed group size of four. Each input byte is taken apart most significant bit first. The bits are read as runs of zeros, each run closed by a one. For every complete group of four zeros the coder writes a single '1'. When a one closes a run, the coder writes a '0' as a divider, followed by the leftover zero count as a two-bit remainder.

The total input length in bytes is presented on `src_len` while reset is held. Once reset is released, the encoder first writes that length as a four-byte header. It then accepts exactly that many input bytes and writes the code bits, packed most significant bit first into bytes on a valid/ready output. When the input is used up, two more steps follow. A run left open by trailing zeros is closed as though a one had followed it. The last byte is then filled out with zeros. After that the encoder raises `done` and stays idle until the next reset.

Top module: `golomb4_encoder`

## Requirements
- R1: On a clock edge with `rst_n` low, the block captures `src_len` and clears its state. From the next cycle `out_valid` and `done` read 0.
- R2: The first four output bytes are the captured length, most significant byte first.
- R3: Each input 0 adds one to the run count. On the fourth 0 since the last code for that run, a single '1' is emitted and the count returns to 0.
- R4: An input 1 emits a '0', then the run count as two bits (high bit first), and clears the count.
- R5: Input bytes are consumed from bit 7 down to bit 0. Code bits fill each output byte from bit 7 down to bit 0.
- R6: If the final input bit is 0, the coder emits a '0' and the two-bit count, as if a 1 had been appended. This also applies when the count is 0 after a full group.
- R7: A final partial byte is completed with '0' bits. When the code bits already end on a byte boundary, no extra byte is sent.
- R8: `done` rises only after the last output byte has been accepted, and it is never high together with `out_valid`.
- R9: Once `done` is high, it stays high. `in_ready` and `out_valid` stay 0 whatever the inputs do, until reset.
- R10: A length of zero produces the four header bytes (all zero) and nothing else before `done`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_len | input | 32 | Input length in bytes, captured while reset is low |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Encoder takes the input byte at this edge |
| out_data | output | 8 | Encoded byte (header, then code) |
| out_valid | output | 1 | Encoded byte is present |
| out_ready | input | 1 | Downstream takes the output byte at this edge |
| done | output | 1 | All bytes delivered; encoder idle until reset |

## Verification
Two end-of-stream cases are hard to reach from the ports. The first is the closing step when the input ends in zeros and a full group of four has just brought the count back to 0. The second is a code length that ends exactly on a byte boundary, where padding must add nothing. Single-byte streams were chosen with a hand-worked code for each (0x10, 0x00, 0xFF) to land on these cases. Every case also runs under a repeating `out_ready` pattern. This stalls the packer on its last bit of a byte while the coder is still in the middle of a remainder, so the hold and completion rules are tested under back-pressure.

// File: rtl/golomb4_pkg.sv
// Package: shared constants and the coder state type for the group-of-four
// Golomb encoder. Assumes byte-wide input and output.
package golomb4_pkg;

    // Byte width on both sides of the encoder.
    localparam int BYTE_W = 8;

    // log2 of the group size; four zeros make one group.
    localparam int GRP_BITS = 2;

    // Coder sequence: header, run scanning, two remainder bits,
    // zero fill, wait for the output slot to empty, finished.
    typedef enum logic [2:0] {
        ST_HDR    = 3'd0,
        ST_RUN    = 3'd1,
        ST_REM_HI = 3'd2,
        ST_REM_LO = 3'd3,
        ST_FILL   = 3'd4,
        ST_DRAIN  = 3'd5,
        ST_FIN    = 3'd6
    } coder_state_t;

endpackage

// File: rtl/g4_bit_source.sv
// Module: g4_bit_source
// Takes input bytes on a valid/ready port and offers them one bit at a time,
// bit 7 first. Holds a count of bytes still owed, loaded from len_i while
// reset is low. Accepts a new byte in the same cycle the last bit of the
// previous one is taken. Assumes the consumer pulses take only when
// bit_avail is high.
module g4_bit_source #(
    parameter int LEN_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              bit_avail,
    output logic              bit_val,
    output logic              exhausted
);

    localparam int POS_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] hold_q;
    logic [POS_W-1:0]  pos_q;
    logic              full_q;
    logic [LEN_W-1:0]  left_q;
    logic              last_bit;
    logic              load;

    // Last bit of the held byte is being offered.
    assign last_bit  = (pos_q == POS_W'(BYTE_W - 1));
    // Room for a byte if more are owed and the holder is free or emptying now.
    assign in_ready  = (left_q != '0) && (!full_q || (take && last_bit));
    assign load      = in_valid && in_ready;
    assign bit_avail = full_q;
    assign bit_val   = hold_q[BYTE_W-1];
    // R9: nothing owed and nothing held marks the end of the input.
    assign exhausted = (left_q == '0) && !full_q;

    // Byte holder, bit position and owed-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pos_q  <= '0;
            full_q <= 1'b0;
            left_q <= len_i;
        end else if (load) begin
            hold_q <= in_data;
            pos_q  <= '0;
            full_q <= 1'b1;
            left_q <= left_q - 1'b1;
        end else if (take) begin
            hold_q <= {hold_q[BYTE_W-2:0], 1'b0};
            pos_q  <= pos_q + 1'b1;
            if (last_bit) begin
                full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/g4_byte_packer.sv
// Module: g4_byte_packer
// Gathers single bits into bytes, first bit at the top, and presents each
// full byte on a one-entry valid/ready output register. A bit is refused
// only when it would complete a byte while the output register is still
// occupied. Reports byte alignment and an empty output register.
module g4_byte_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_val,
    output logic              bit_ready,
    output logic              aligned,
    output logic              empty,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] acc_q;
    logic [CNT_W-1:0]  fill_q;
    logic [BYTE_W-1:0] obyte_q;
    logic              ovalid_q;
    logic              slot_free;
    logic              closing;
    logic              accept;

    assign slot_free = !ovalid_q || out_ready;
    assign closing   = (fill_q == CNT_W'(BYTE_W - 1));
    assign bit_ready = !closing || slot_free;
    assign accept    = bit_valid && bit_ready;
    assign aligned   = (fill_q == '0);
    assign empty     = !ovalid_q;
    assign out_data  = obyte_q;
    assign out_valid = ovalid_q;

    // Partial byte accumulator and its fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (accept) begin
            if (closing) begin
                fill_q <= '0;
            end else begin
                acc_q  <= {acc_q[BYTE_W-3:0], bit_val};
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // Output register: loads on a completed byte, clears when taken (R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obyte_q  <= '0;
            ovalid_q <= 1'b0;
        end else if (accept && closing) begin
            obyte_q  <= {acc_q, bit_val};
            ovalid_q <= 1'b1;
        end else if (out_ready) begin
            ovalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/g4_run_coder.sv
// Module: g4_run_coder
// Sequencer of the encoder. Sends the length header bit by bit, then turns
// input bits into Golomb code bits (group of four), closes a run left open
// by trailing zeros, fills the last byte with zeros and waits for the output
// register to empty before finishing. At most one code bit per cycle;
// a code bit and the input bit behind it move together.
module g4_run_coder
    import golomb4_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_i,
    input  logic             bit_avail,
    input  logic             bit_val,
    input  logic             exhausted,
    output logic             take,
    output logic             emit_valid,
    output logic             emit_bit,
    input  logic             emit_ready,
    input  logic             aligned,
    input  logic             empty,
    output logic             done
);

    localparam int HCNT_W = $clog2(LEN_W);

    coder_state_t        st_q, st_d;
    logic [LEN_W-1:0]    hdr_q;
    logic [HCNT_W-1:0]   hcnt_q;
    logic [GRP_BITS-1:0] run_q, run_d;
    logic                lastz_q, lastz_d;
    logic                hdr_step;

    // Next-state, code-bit and input-take decisions.
    always_comb begin
        st_d       = st_q;
        run_d      = run_q;
        lastz_d    = lastz_q;
        take       = 1'b0;
        emit_valid = 1'b0;
        emit_bit   = 1'b0;
        hdr_step   = 1'b0;
        unique case (st_q)
            ST_HDR: begin
                // R2: header bits, most significant first.
                emit_valid = 1'b1;
                emit_bit   = hdr_q[LEN_W-1];
                if (emit_ready) begin
                    hdr_step = 1'b1;
                    if (hcnt_q == HCNT_W'(LEN_W - 1)) begin
                        st_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (bit_avail) begin
                    if (bit_val) begin
                        // R4: a one writes the divider, then the remainder.
                        emit_valid = 1'b1;
                        emit_bit   = 1'b0;
                        if (emit_ready) begin
                            take    = 1'b1;
                            lastz_d = 1'b0;
                            st_d    = ST_REM_HI;
                        end
                    end else if (run_q == '1) begin
                        // R3: fourth zero completes a group.
                        emit_valid = 1'b1;
                        emit_bit   = 1'b1;
                        if (emit_ready) begin
                            take    = 1'b1;
                            lastz_d = 1'b1;
                            run_d   = '0;
                        end
                    end else begin
                        take    = 1'b1;
                        lastz_d = 1'b1;
                        run_d   = run_q + 1'b1;
                    end
                end else if (exhausted) begin
                    if (lastz_q) begin
                        // R6: close the open run with an implied one.
                        emit_valid = 1'b1;
                        emit_bit   = 1'b0;
                        if (emit_ready) begin
                            lastz_d = 1'b0;
                            st_d    = ST_REM_HI;
                        end
                    end else begin
                        st_d = ST_FILL;
                    end
                end
            end
            ST_REM_HI: begin
                emit_valid = 1'b1;
                emit_bit   = run_q[GRP_BITS-1];
                if (emit_ready) begin
                    st_d = ST_REM_LO;
                end
            end
            ST_REM_LO: begin
                emit_valid = 1'b1;
                emit_bit   = run_q[0];
                if (emit_ready) begin
                    run_d = '0;
                    st_d  = ST_RUN;
                end
            end
            ST_FILL: begin
                // R7: zero bits until the byte boundary.
                if (aligned) begin
                    st_d = ST_DRAIN;
                end else begin
                    emit_valid = 1'b1;
                    emit_bit   = 1'b0;
                end
            end
            ST_DRAIN: begin
                // R8: finish only once the last byte has left.
                if (empty) begin
                    st_d = ST_FIN;
                end
            end
            ST_FIN: begin
                st_d = ST_FIN;
            end
            default: begin
                st_d = ST_FIN;
            end
        endcase
    end

    // State, run count and trailing-zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HDR;
            run_q   <= '0;
            lastz_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            run_q   <= run_d;
            lastz_q <= lastz_d;
        end
    end

    // Header shifter and bit counter, loaded with the length under reset (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= len_i;
            hcnt_q <= '0;
        end else if (hdr_step) begin
            hdr_q  <= {hdr_q[LEN_W-2:0], 1'b0};
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign done = (st_q == ST_FIN);

endmodule

// File: rtl/golomb4_encoder.sv
// Module: golomb4_encoder (top)
// Golomb encoder with group size four: input bytes -> bit source ->
// run coder -> byte packer -> output bytes. The length is taken from
// src_len during reset and written as a four-byte header first.
// Assumes LEN_W is a multiple of the byte width.
module golomb4_encoder
    import golomb4_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  src_len,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done
);

    logic bit_avail;
    logic bit_val;
    logic exhausted;
    logic take;
    logic emit_valid;
    logic emit_bit;
    logic emit_ready;
    logic aligned;
    logic empty;

    g4_bit_source #(
        .LEN_W  (LEN_W),
        .BYTE_W (BYTE_W)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_i     (src_len),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .take      (take),
        .bit_avail (bit_avail),
        .bit_val   (bit_val),
        .exhausted (exhausted)
    );

    g4_run_coder #(
        .LEN_W (LEN_W)
    ) u_coder (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_i      (src_len),
        .bit_avail  (bit_avail),
        .bit_val    (bit_val),
        .exhausted  (exhausted),
        .take       (take),
        .emit_valid (emit_valid),
        .emit_bit   (emit_bit),
        .emit_ready (emit_ready),
        .aligned    (aligned),
        .empty      (empty),
        .done       (done)
    );

    g4_byte_packer #(
        .BYTE_W (BYTE_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (emit_valid),
        .bit_val   (emit_bit),
        .bit_ready (emit_ready),
        .aligned   (aligned),
        .empty     (empty),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

endmodule

// File: rtl/golomb4_encoder_chk.sv
// Module: golomb4_encoder_chk
// Port-level properties of the encoder, attached to every instance by bind.
// Keeps its own copy of the length and a count of header bytes accepted.
module golomb4_encoder_chk #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] src_len,
    input logic             in_ready,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             done
);

    localparam int HDR_BYTES = LEN_W / 8;
    localparam int HC_W      = $clog2(HDR_BYTES + 1);

    logic [LEN_W-1:0] cap_q;
    logic [HC_W-1:0]  hc_q;
    logic [7:0]       want;

    // Length copy and header byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= src_len;
            hc_q  <= '0;
        end else if (out_valid && out_ready && (hc_q < HC_W'(HDR_BYTES))) begin
            hc_q <= hc_q + 1'b1;
        end
    end

    assign want = 8'(cap_q >> (8 * (HDR_BYTES - 1 - int'(hc_q))));

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !done)); // R1

    AST_HEADER_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (hc_q < HC_W'(HDR_BYTES))) |-> (out_data == want)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !in_ready)); // R8

endmodule

bind golomb4_encoder golomb4_encoder_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_len   (src_len),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .done      (done)
);

// File: tb/golomb4_encoder_test.sv
// Bench for golomb4_encoder: a vector table of single- and two-byte streams
// with hand-worked results, then directed tests for reset, zero length,
// input after completion and a long stream. Expected bytes also come from
// a bench model written from the requirements.
module golomb4_encoder_test;

    localparam int LEN_W = 32;

    // {len, data (left aligned), out_ready pattern, total bytes, last byte}
    localparam logic [63:0] VEC [7] = '{
        {8'd1, 32'h8000_0000, 8'hFF, 8'd5, 8'h16},  // R4 R3 R6
        {8'd1, 32'hFF00_0000, 8'hFF, 8'd7, 8'h00},  // R4, aligned end R7
        {8'd1, 32'h0000_0000, 8'hA5, 8'd5, 8'hC0},  // R3 R6 with count 0
        {8'd1, 32'h0100_0000, 8'h33, 8'd5, 8'hB0},  // R3 R4 R5
        {8'd2, 32'h0FF0_0000, 8'hFF, 8'd8, 8'h40},  // R5 two bytes, R6
        {8'd1, 32'h4000_0000, 8'h0F, 8'd5, 8'h34},  // R4 remainder 01, R11
        {8'd1, 32'h1000_0000, 8'hFF, 8'd5, 8'h70}   // R6 after full group
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LEN_W-1:0]  src_len;
    logic [7:0]        in_data;
    logic              in_valid;
    logic              in_ready;
    logic [7:0]        out_data;
    logic              out_valid;
    logic              out_ready;
    logic              done;

    always #4 clk = ~clk;

    golomb4_encoder #(.LEN_W(LEN_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_len   (src_len),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .done      (done)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] sbuf [0:63];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    int         hold_err;
    int         early_done;
    logic       run_done;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected output bytes from the requirements (R2..R7, R10).
    task automatic build_exp(input int n);
        bit bits [$];
        int cnt;
        bit lastz;
        exp_q.delete();
        for (int i = LEN_W - 1; i >= 0; i--) bits.push_back(n[i]);
        cnt = 0;
        lastz = 1'b0;
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (sbuf[b][i]) begin
                    bits.push_back(1'b0);
                    bits.push_back(cnt[1]);
                    bits.push_back(cnt[0]);
                    cnt = 0;
                    lastz = 1'b0;
                end else begin
                    cnt++;
                    lastz = 1'b1;
                    if (cnt == 4) begin
                        bits.push_back(1'b1);
                        cnt = 0;
                    end
                end
            end
        end
        if (lastz) begin
            bits.push_back(1'b0);
            bits.push_back(cnt[1]);
            bits.push_back(cnt[0]);
        end
        while ((bits.size() % 8) != 0) bits.push_back(1'b0);
        for (int k = 0; k < bits.size(); k += 8) begin
            logic [7:0] v;
            for (int j = 0; j < 8; j++) v[7-j] = bits[k+j];
            exp_q.push_back(v);
        end
    endtask

    task automatic do_reset(input int n);
        src_len   = LEN_W'(n);
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one stream and collect its output until done.
    task automatic run_case(input int n, input logic [7:0] pat, input int max_cyc);
        int   idx;
        int   cyc;
        bit   pend;
        logic [7:0] pdat;
        do_reset(n);
        got_q.delete();
        idx = 0;
        cyc = 0;
        pend = 1'b0;
        pdat = 8'h00;
        hold_err = 0;
        early_done = 0;
        run_done = 1'b0;
        while (cyc < max_cyc) begin
            @(negedge clk);
            out_ready = pat[cyc % 8];
            in_valid  = (idx < n);
            in_data   = (idx < n) ? sbuf[idx] : 8'h00;
            #1;
            if (pend && !(out_valid && out_data == pdat)) hold_err++;
            pend = out_valid && !out_ready;
            pdat = out_data;
            if (done && out_valid) early_done++;
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (in_valid && in_ready) idx++;
            if (done) begin
                run_done = 1'b1;
                break;
            end
            cyc++;
        end
        in_valid = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        check(run_done, "R8", {tag, " done raised"}, 32'(run_done), 32'd1);
        check(early_done == 0, "R8", {tag, " done with out_valid"}, 32'(early_done), 32'd0);
        check(hold_err == 0, "R11", {tag, " output held under stall"}, 32'(hold_err), 32'd0);
        check(got_q.size() == exp_q.size(), "R7", {tag, " byte count"},
              32'(got_q.size()), 32'(exp_q.size()));
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++) begin
            check(got_q[k] == exp_q[k], (k < 4) ? "R2" : "R5",
                  $sformatf("%s byte %0d", tag, k), 32'(got_q[k]), 32'(exp_q[k]));
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: outputs quiet under reset.
        do_reset(3);
        #1;
        check(!out_valid && !done, "R1", "reset state", {30'd0, out_valid, done}, 32'd0);

        // Table of hand-worked streams.
        for (int r = 0; r < 7; r++) begin
            int         n;
            logic [7:0] pat;
            n   = int'(VEC[r][63:56]);
            pat = VEC[r][23:16];
            for (int b = 0; b < 4; b++) sbuf[b] = VEC[r][55 - 8*b -: 8];
            build_exp(n);
            run_case(n, pat, 2000);
            compare_all($sformatf("row%0d", r));
            check(got_q.size() == int'(VEC[r][15:8]), "R7",
                  $sformatf("row%0d hand count", r), 32'(got_q.size()), 32'(VEC[r][15:8]));
            if (got_q.size() > 0) begin
                check(got_q[got_q.size()-1] == VEC[r][7:0], "R6",
                      $sformatf("row%0d last byte padded", r),
                      32'(got_q[got_q.size()-1]), 32'(VEC[r][7:0]));
            end
        end

        // R9: after done, input is refused and no output appears.
        begin
            int bad;
            bad = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_data   = 8'(c * 17);
                out_ready = 1'b1;
                #1;
                if (in_ready || out_valid || !done) bad++;
            end
            in_valid = 1'b0;
            check(bad == 0, "R9", "idle after done", 32'(bad), 32'd0);
        end

        // R1: reset after completion clears done.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(!done && !out_valid, "R1", "reset after done", {30'd0, out_valid, done}, 32'd0);

        // R10: zero length gives only the header.
        build_exp(0);
        run_case(0, 8'h6D, 2000);
        compare_all("zero length");
        check(got_q.size() == 4, "R10", "header only", 32'(got_q.size()), 32'd4);

        // R3 R4 R5: long stream with mixed runs and back-pressure.
        for (int b = 0; b < 48; b++) begin
            sbuf[b] = 8'((b * 73 + 29) ^ (b >> 2));
        end
        sbuf[10] = 8'h00;
        sbuf[11] = 8'h00;
        sbuf[47] = 8'h80;
        build_exp(48);
        run_case(48, 8'h6D, 20000);
        compare_all("long stream");

        finish_run();
    end

endmodule